// File: doc/BRIEF.md
# Row-Column Bit Interleaver

This block spreads adjacent coded bits apart before symbol mapping. It treats each OFDM symbol's coded bits as one independent block. Serial input bits fill a matrix one row at a time, left to right. The matrix is then emptied one column at a time, top to bottom. Burst errors on the channel therefore land on bits that sit far apart in the coded stream.

The block has two shapes. In data mode the matrix has 15 columns, and a 2-bit modulation index sets the block length. In header mode the block has a fixed length of 72 bits and the matrix has 18 columns. The mode and the modulation index are captured on the input bit flagged as start.

Two block buffers alternate, so a new block can be written while the previous one streams out. Upstream logic must not start block n before block n-2 has fully left the output.

Top module: `row_col_interleaver`

## Requirements
- R1: In data mode (`hdr_mode`=0) the block holds 60, 120, 240 or 360 bits for `mod_idx` 0, 1, 2 or 3, and the matrix has 15 columns. Exactly that many bits leave the output between `out_start` and `out_end`, inclusive.
- R2: In header mode (`hdr_mode`=1) the block holds 72 bits and the matrix has 18 columns, whatever the value of `mod_idx`.
- R3: Take a block of N bits and C columns, and let R = N/C be the number of rows. Input bit k sits at row k/C, column k%C. It leaves as output bit number (k%C)*R + k/C of the block.
- R4: `hdr_mode` and `mod_idx` are sampled only on the accepted bit that has `in_start`=1. Changing them on later bits of the same block has no effect on the length or the order of the output.
- R5: A block's first output bit appears at least two cycles after its last input bit is accepted. From `out_start` to `out_end`, the block then streams with `out_valid` high on every cycle.
- R6: `out_start` marks only the first bit of a block and `out_end` only the last, and both occur only with `out_valid`. `out_valid` is low on the cycle after `out_end`.
- R7: An input bit with `in_valid`=1 and `in_start`=0 is dropped when no block is open. It produces no output and does not enter the next block.
- R8: A bit with `in_start`=1 that arrives while a block is open drops the open block. A new block begins at bit 0 with a freshly sampled configuration, and the dropped bits never reach the output.
- R9: A block may be written while the previous block is being read. Blocks leave in the order they were written, and a finished block never lands in a buffer that still holds an unread block.
- R10: While reset is active, `out_valid`, `out_start` and `out_end` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit is present |
| in_bit | input | 1 | Serial coded bit |
| in_start | input | 1 | First bit of a block; samples the configuration |
| hdr_mode | input | 1 | 1 selects the fixed header shape, 0 the data shape |
| mod_idx | input | 2 | Modulation index that sets the data block length |
| out_valid | output | 1 | Output bit is present |
| out_bit | output | 1 | Interleaved serial bit |
| out_start | output | 1 | First output bit of a block |
| out_end | output | 1 | Last output bit of a block |

## Verification
The bench builds the block with its default parameters: a 360-bit buffer, a 60-bit base length, 15 data columns, and a header shape of 72 bits by 18 columns. These values reach every data length, the header shape, and the largest block, which fills the buffer exactly, so the final address and the row wrap at 24 rows are both exercised. Blocks of mixed lengths are sent back to back. A short block is written while a long one drains, which exercises buffer alternation and the spacing rule between blocks.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Bits in one block: fixed in header mode, a multiple of the base length otherwise.
  function automatic int blk_bits(input logic hdr, input logic [1:0] mod,
                                  input int base, input int hbits);
    if (hdr) return hbits;
    if (mod == 2'd3) return base * 6;
    return base << mod;
  endfunction

  function automatic int blk_cols(input logic hdr, input int dcols, input int hcols);
    return hdr ? hcols : dcols;
  endfunction

  function automatic int blk_rows(input logic hdr, input logic [1:0] mod, input int base,
                                  input int hbits, input int dcols, input int hcols);
    return blk_bits(hdr, mod, base, hbits) / blk_cols(hdr, dcols, hcols);
  endfunction

endpackage

// File: rtl/ilv_wr_ctrl.sv
module ilv_wr_ctrl import ilv_pkg::*; #(
  parameter int BASE_BITS = 60,
  parameter int DATA_COLS = 15,
  parameter int HDR_BITS  = 72,
  parameter int HDR_COLS  = 18,
  parameter int AW        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic          hdr_mode,
  input  logic [1:0]    mod_idx,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic          blk_done,
  output logic [AW-1:0] done_cols,
  output logic [AW-1:0] done_rows
);
  logic          active_q;
  logic [AW-1:0] cnt_q, size_q, cols_q, rows_q;
  logic [AW-1:0] new_size, new_cols, new_rows, cur_size;

  assign new_size = AW'(blk_bits(hdr_mode, mod_idx, BASE_BITS, HDR_BITS));
  assign new_cols = AW'(blk_cols(hdr_mode, DATA_COLS, HDR_COLS));
  assign new_rows = AW'(blk_rows(hdr_mode, mod_idx, BASE_BITS, HDR_BITS, DATA_COLS, HDR_COLS));

  assign wr_en     = in_valid & (in_start | active_q);
  assign wr_addr   = in_start ? '0 : cnt_q;
  assign cur_size  = in_start ? new_size : size_q;
  assign done_cols = in_start ? new_cols : cols_q;
  assign done_rows = in_start ? new_rows : rows_q;
  assign blk_done  = wr_en && (wr_addr == cur_size - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_bank  <= 1'b0;
      cnt_q    <= '0;
      size_q   <= '0;
      cols_q   <= '0;
      rows_q   <= '0;
    end else if (wr_en) begin
      if (in_start) begin
        size_q <= new_size;
        cols_q <= new_cols;
        rows_q <= new_rows;
      end
      if (blk_done) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
        wr_bank  <= ~wr_bank;
      end else begin
        active_q <= 1'b1;
        cnt_q    <= wr_addr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ilv_rd_ctrl.sv
module ilv_rd_ctrl #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_done,
  input  logic          done_bank,
  input  logic [AW-1:0] done_cols,
  input  logic [AW-1:0] done_rows,
  output logic          rd_fire,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic          rd_first,
  output logic          rd_last,
  output logic [1:0]    bank_full
);
  logic [AW-1:0] meta_cols [2];
  logic [AW-1:0] meta_rows [2];
  logic          busy_q, next_q;
  logic [AW-1:0] row_q, col_q, cols_q, rows_q;
  logic          row_wrap;

  assign rd_fire  = busy_q;
  assign row_wrap = (row_q == rows_q - 1'b1);
  assign rd_first = busy_q && (row_q == '0) && (col_q == '0);
  assign rd_last  = busy_q && row_wrap && (col_q == cols_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_full <= 2'b00;
      busy_q    <= 1'b0;
      next_q    <= 1'b0;
      rd_bank   <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      rd_addr   <= '0;
      cols_q    <= '0;
      rows_q    <= '0;
      for (int b = 0; b < 2; b++) begin
        meta_cols[b] <= '0;
        meta_rows[b] <= '0;
      end
    end else begin
      if (busy_q) begin
        if (row_wrap) begin
          row_q   <= '0;
          col_q   <= col_q + 1'b1;
          rd_addr <= col_q + 1'b1;
        end else begin
          row_q   <= row_q + 1'b1;
          rd_addr <= rd_addr + cols_q;
        end
        if (rd_last) begin
          busy_q             <= 1'b0;
          bank_full[rd_bank] <= 1'b0;
          next_q             <= ~next_q;
        end
      end else if (bank_full[next_q]) begin
        busy_q  <= 1'b1;
        rd_bank <= next_q;
        row_q   <= '0;
        col_q   <= '0;
        rd_addr <= '0;
        cols_q  <= meta_cols[next_q];
        rows_q  <= meta_rows[next_q];
      end
      if (blk_done) begin
        bank_full[done_bank] <= 1'b1;
        meta_cols[done_bank] <= done_cols;
        meta_rows[done_bank] <= done_rows;
      end
    end
  end
endmodule

// File: rtl/ilv_bank_store.sv
module ilv_bank_store #(
  parameter int MAX_BITS = 360,
  parameter int AW       = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic          rd_en,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  logic [MAX_BITS-1:0] mem [2];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_bank][wr_addr] <= wr_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_bit <= 1'b0;
    else if (rd_en) rd_bit <= mem[rd_bank][rd_addr];
  end
endmodule

// File: rtl/row_col_interleaver.sv
module row_col_interleaver #(
  parameter int MAX_BITS  = 360,
  parameter int BASE_BITS = 60,
  parameter int DATA_COLS = 15,
  parameter int HDR_BITS  = 72,
  parameter int HDR_COLS  = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       in_start,
  input  logic       hdr_mode,
  input  logic [1:0] mod_idx,
  output logic       out_valid,
  output logic       out_bit,
  output logic       out_start,
  output logic       out_end
);
  localparam int AW = $clog2(MAX_BITS + 1);

  // Named internal events, also observed by the bound checker.
  logic          wr_en, wr_bank, blk_done;
  logic [AW-1:0] wr_addr, done_cols, done_rows;
  logic          rd_fire, rd_bank, rd_first, rd_last;
  logic [AW-1:0] rd_addr;
  logic [1:0]    bank_full;
  logic          done_bank;

  assign done_bank = wr_bank;

  ilv_wr_ctrl #(
    .BASE_BITS(BASE_BITS), .DATA_COLS(DATA_COLS),
    .HDR_BITS(HDR_BITS), .HDR_COLS(HDR_COLS), .AW(AW)
  ) wr_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .hdr_mode(hdr_mode), .mod_idx(mod_idx), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .blk_done(blk_done), .done_cols(done_cols), .done_rows(done_rows)
  );

  ilv_rd_ctrl #(.AW(AW)) rd_i (
    .clk(clk), .rst_n(rst_n), .blk_done(blk_done), .done_bank(done_bank),
    .done_cols(done_cols), .done_rows(done_rows), .rd_fire(rd_fire), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .rd_first(rd_first), .rd_last(rd_last), .bank_full(bank_full)
  );

  ilv_bank_store #(.MAX_BITS(MAX_BITS), .AW(AW)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_bit(in_bit), .rd_en(rd_fire), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .rd_bit(out_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_start <= 1'b0;
      out_end   <= 1'b0;
    end else begin
      out_valid <= rd_fire;
      out_start <= rd_first;
      out_end   <= rd_last;
    end
  end
endmodule

// File: rtl/ilv_chk.sv
module ilv_chk #(
  parameter int MAX_BITS = 360,
  parameter int AW       = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_start,
  input logic          out_end,
  input logic          blk_done,
  input logic          done_bank,
  input logic [1:0]    bank_full,
  input logic          rd_fire,
  input logic [AW-1:0] rd_addr
);
  // R6
  start_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid);
  // R6
  end_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |-> out_valid);
  // R6
  gap_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |=> !out_valid);
  // R5
  no_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_start) |-> $past(out_valid));
  // R9
  no_clobber_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> !bank_full[done_bank]);
  // R1
  rd_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> (rd_addr < AW'(MAX_BITS)));
endmodule

bind row_col_interleaver ilv_chk #(.MAX_BITS(MAX_BITS), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_start(out_start),
  .out_end(out_end), .blk_done(blk_done), .done_bank(done_bank),
  .bank_full(bank_full), .rd_fire(rd_fire), .rd_addr(rd_addr)
);

// File: tb/row_col_interleaver_tb_top.sv
module row_col_interleaver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB   = 360;
  localparam int BASEB  = 60;
  localparam int DCOLS  = 15;
  localparam int HBITS  = 72;
  localparam int HCOLS  = 18;
  localparam int MAXBLK = 64;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_start = 1'b0, hdr_mode = 1'b0;
  logic [1:0] mod_idx = 2'd0;
  logic out_valid, out_bit, out_start, out_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  row_col_interleaver dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_start(in_start), .hdr_mode(hdr_mode), .mod_idx(mod_idx),
    .out_valid(out_valid), .out_bit(out_bit), .out_start(out_start), .out_end(out_end)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, n_exp = 0, blk_rx = 0, pos = 0;
  bit prev_end = 1'b0, done = 1'b0;
  logic [MAXB-1:0] exp_in [MAXBLK];
  int exp_len [MAXBLK];
  int exp_cols [MAXBLK];
  int last_in_cyc [MAXBLK];
  string exp_tag [MAXBLK];
  logic [MAXB-1:0] got = '0;

  function automatic int b_len(bit h, int m);
    if (h) return HBITS;
    case (m)
      0: return BASEB;
      1: return 2 * BASEB;
      2: return 4 * BASEB;
      default: return 6 * BASEB;
    endcase
  endfunction

  function automatic int b_cols(bit h);
    return h ? HCOLS : DCOLS;
  endfunction

  // Expected output: output position p reads row p%R, column p/R of the written matrix.
  function automatic logic [MAXB-1:0] b_scramble(logic [MAXB-1:0] src, int len, int cols);
    logic [MAXB-1:0] res = '0;
    int rows = len / cols;
    for (int p = 0; p < len; p++) res[p] = src[(p % rows) * cols + (p / rows)];
    return res;
  endfunction

  task automatic chk(bit ok, string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d blocks exp %0d", blk_rx, n_exp);
      summary();
    end
  end

  // Output collector
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_end) chk(!out_valid, $sformatf("R6 valid after end: got %0b exp 0", out_valid));
      prev_end = out_valid && out_end;
      if (out_valid) begin
        if (blk_rx >= n_exp) begin
          chk(1'b0, $sformatf("R7 unexpected output bit: got 1 exp 0 (blocks %0d)", n_exp));
        end else begin
          if (pos == 0) begin
            chk(out_start == 1'b1, $sformatf("R6 start on first bit blk %0d: got %0b exp 1",
                                             blk_rx, out_start));
            chk(cyc > last_in_cyc[blk_rx] + 1, $sformatf("R5 early output blk %0d: got cyc %0d exp >%0d",
                                                         blk_rx, cyc, last_in_cyc[blk_rx] + 1));
          end else if (out_start) begin
            chk(1'b0, $sformatf("R6 stray start blk %0d pos %0d: got 1 exp 0", blk_rx, pos));
          end
          if (pos < MAXB) got[pos] = out_bit;
          pos++;
          if (out_end) begin
            chk(pos == exp_len[blk_rx], $sformatf("%s length R1/R2 blk %0d: got %0d exp %0d",
                                                  exp_tag[blk_rx], blk_rx, pos, exp_len[blk_rx]));
            chk(got == b_scramble(exp_in[blk_rx], exp_len[blk_rx], exp_cols[blk_rx]),
                $sformatf("%s/R3 content blk %0d: got %h exp %h", exp_tag[blk_rx], blk_rx, got,
                          b_scramble(exp_in[blk_rx], exp_len[blk_rx], exp_cols[blk_rx])));
            blk_rx++;
            pos = 0;
            got = '0;
          end else if (pos == exp_len[blk_rx] + 1) begin
            chk(1'b0, $sformatf("R6 missing end blk %0d: got %0d bits exp %0d",
                                blk_rx, pos, exp_len[blk_rx]));
          end
        end
      end
    end
  end

  task automatic drive_idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_start = 1'b0;
    in_bit   = 1'($urandom);
  endtask

  task automatic pace();
    while (blk_rx + 1 < n_exp) @(negedge clk);
  endtask

  task automatic send_block(bit h, logic [1:0] m, int gap_pct, bit wiggle, string tag);
    logic [MAXB-1:0] v = '0;
    int len = b_len(h, int'(m));
    int idx;
    pace();
    for (int i = 0; i < len; i++) v[i] = 1'($urandom);
    idx = n_exp;
    exp_in[idx] = v;
    exp_len[idx] = len;
    exp_cols[idx] = b_cols(h);
    exp_tag[idx] = tag;
    last_in_cyc[idx] = 1 << 30;
    n_exp++;
    for (int k = 0; k < len; k++) begin
      while (int'($urandom % 100) < gap_pct) drive_idle();
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = v[k];
      in_start = (k == 0);
      if (k == 0 || !wiggle) begin
        hdr_mode = h;
        mod_idx  = m;
      end else begin
        hdr_mode = 1'($urandom);
        mod_idx  = 2'($urandom);
      end
    end
    last_in_cyc[idx] = cyc;
    @(negedge clk);
    in_valid = 1'b0;
    in_start = 1'b0;
  endtask

  task automatic send_partial(bit h, logic [1:0] m, int nbits);
    pace();
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = 1'($urandom);
      in_start = (k == 0);
      hdr_mode = h;
      mod_idx  = m;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(out_valid == 1'b0, $sformatf("R10 out_valid in reset: got %0b exp 0", out_valid));
    chk(out_start == 1'b0, $sformatf("R10 out_start in reset: got %0b exp 0", out_start));
    chk(out_end == 1'b0, $sformatf("R10 out_end in reset: got %0b exp 0", out_end));
    rst_n = 1'b1;

    // R1: each data length, R2: header shape
    for (int m = 0; m < 4; m++) send_block(1'b0, 2'(m), 0, 1'b0, "R1");
    send_block(1'b1, 2'd0, 20, 1'b0, "R2");
    send_block(1'b1, 2'd3, 0, 1'b0, "R2");
    // R4: configuration changes after the start bit
    send_block(1'b1, 2'd2, 10, 1'b1, "R4");
    send_block(1'b0, 2'd3, 10, 1'b1, "R4");

    // R7: valid bits with no open block
    repeat (12) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_start = 1'b0;
      in_bit   = 1'($urandom);
    end
    @(negedge clk);
    in_valid = 1'b0;
    send_block(1'b0, 2'd1, 10, 1'b0, "R7");

    // R8: restart of an open block
    send_partial(1'b0, 2'd3, 50);
    send_block(1'b1, 2'd0, 0, 1'b0, "R8");
    send_partial(1'b1, 2'd0, 30);
    send_block(1'b0, 2'd2, 0, 1'b0, "R8");

    // R9: back to back, long and short mixed
    send_block(1'b0, 2'd3, 0, 1'b0, "R9");
    send_block(1'b0, 2'd0, 0, 1'b0, "R9");
    send_block(1'b1, 2'd1, 0, 1'b0, "R9");
    send_block(1'b0, 2'd3, 0, 1'b0, "R9");
    send_block(1'b0, 2'd3, 0, 1'b0, "R9");
    send_block(1'b0, 2'd1, 0, 1'b0, "R9");

    // Random mix
    repeat (20) send_block(1'($urandom), 2'($urandom), int'($urandom % 30), 1'b1, "R4");

    while (blk_rx < n_exp) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(blk_rx == n_exp, $sformatf("R9 block count: got %0d exp %0d", blk_rx, n_exp));
    done = 1'b1;
    summary();
  end
endmodule